// File: doc/BRIEF.md
# Packet type detection buffer

This block sits ahead of a serial receive buffer. It watches the decoded receive bit stream. When a packet-start marker arrives, it captures the first two valid bits of the packet identifier in a two-bit holding register. From those two bits alone it classifies the packet as token, data or handshake. It does not decode the full identifier.

A classification sets a sticky bit in a small receive status register. It also fires a one-cycle detection pulse for the class and a one-cycle pointer-restart pulse for the pointer logic of the transmit/receive buffer. A registered bank-select output is updated at the same time and tells the pointer logic which store area to use. Token packets go to the token area. Data and handshake packets share the data area.

Software clears the status bits with a single clear strobe. A two-bit value that matches no class is passed over: the status, the bank selection and the pointer logic are left untouched.

Top module: `pkt_class_buf`

## Requirements
- R1: A synchronous reset, while held, gives the following state on every clock: the holding register is cleared, rx_stat is 000, bank_sel is 0, and tok_det, dat_det, hs_det and ptr_restart are all 0.
- R2: Capture works as follows.
  - The first identifier bit is the rx_bit sampled with bit_valid high, either in the same cycle as pkt_start or in a later cycle.
  - The second identifier bit is the next rx_bit sampled with bit_valid high.
  - Cycles with bit_valid low are skipped.
  - Bits that arrive while no capture is armed are ignored.
- R3: The code value is {second bit, first bit}. A code of 2'b01 (first bit 1, second bit 0) is a token. It pulses tok_det, sets rx_stat[0] and drives bank_sel to 0 (token area).
- R4: A code of 2'b11 is a data packet. It pulses dat_det, sets rx_stat[1] and drives bank_sel to 1 (data area).
- R5: A code of 2'b10 (first bit 0, second bit 1) is a handshake. It pulses hs_det, sets rx_stat[2] and drives bank_sel to 1, the same area as data.
- R6: A code of 2'b00 produces the following, observed on the clock after the second bit:
  - no detection pulse and no ptr_restart;
  - no change to rx_stat;
  - no change to bank_sel.
- R7: Detection pulses are high for exactly one cycle. They are registered on the clock edge after the edge that samples the second identifier bit.
- R8: ptr_restart pulses in the same cycle as any detection pulse and at no other time.
- R9: The bits of rx_stat are handled as follows.
  - Once set, a bit stays set until stat_clr is sampled high.
  - stat_clr clears all three bits on the next clock.
  - When stat_clr and a detection fall on the same edge, the detected bit ends up set and the other bits are cleared.
- R10: After the second identifier bit, further valid bits are ignored until the next pkt_start. A pkt_start during a capture discards the partial capture and starts a new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Decoded serial receive bit |
| bit_valid | input | 1 | rx_bit carries a bit this cycle |
| pkt_start | input | 1 | Marks the start of a packet identifier |
| stat_clr | input | 1 | Software clear strobe for rx_stat |
| rx_stat | output | 3 | Sticky status: bit 0 token, bit 1 data, bit 2 handshake |
| bank_sel | output | 1 | Store area: 0 token, 1 data |
| tok_det | output | 1 | One-cycle token detection pulse |
| dat_det | output | 1 | One-cycle data detection pulse |
| hs_det | output | 1 | One-cycle handshake detection pulse |
| ptr_restart | output | 1 | One-cycle restart request to the pointer logic |

## Verification
The bench targets the following corner cases:
- **Bit order.** A token and a handshake carry the same pair of bits in opposite order, so a design that shifts the identifier the wrong way swaps these two classes.
- **Gaps and restarts.** Gaps in bit_valid, bits arriving before pkt_start, payload bits after the identifier, and a pkt_start that lands mid-capture each catch a capture counter that counts the wrong events or fails to rearm.
- **Clear against set.** A clear strobe timed onto the classification edge catches a design that lets the clear win.
- **Unknown code.** A 2'b00 code sent after a data packet catches a bank select that falls back to the token area or a restart that fires for an unknown code.
- **Back-to-back packets.** These catch pulses that stretch beyond one cycle.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
   localparam int NCLS      = 3;
   localparam int CLS_TOK   = 0;
   localparam int CLS_DAT   = 1;
   localparam int CLS_HS    = 2;
   localparam logic BANK_TOKEN = 1'b0;
   localparam logic BANK_DATA  = 1'b1;
   typedef logic [NCLS-1:0] cls_vec_t;
endpackage

// File: rtl/pcb_capture.sv
module pcb_capture #(
   parameter int ID_W = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            rx_bit,
   input  logic            bit_valid,
   input  logic            pkt_start,
   output logic [ID_W-1:0] hold,
   output logic            cap_done
);
   localparam int IW = (ID_W > 1) ? $clog2(ID_W) : 1;
   localparam logic [IW-1:0] LAST = IW'(ID_W - 1);

   if (ID_W < 2) begin : g_bad_width
      $error("pcb_capture: ID_W must be at least 2");
   end

   logic          armed;
   logic [IW-1:0] idx;
   logic [IW-1:0] pos;
   logic          take;

   assign take = bit_valid && (pkt_start || armed);
   assign pos  = pkt_start ? '0 : idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold     <= '0;
         armed    <= 1'b0;
         idx      <= '0;
         cap_done <= 1'b0;
      end else begin
         cap_done <= take && (pos == LAST);
         if (take) begin
            hold[pos] <= rx_bit;
            if (pos == LAST) begin
               armed <= 1'b0;
               idx   <= '0;
            end else begin
               armed <= 1'b1;
               idx   <= IW'(pos + 1'b1);
            end
         end else if (pkt_start) begin
            armed <= 1'b1;
            idx   <= '0;
         end
      end
   end

   // R7
   done_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
      cap_done |-> $past(bit_valid));

   // R10
   hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!armed && !pkt_start) |=> $stable(hold));
endmodule

// File: rtl/pcb_classify.sv
module pcb_classify
   import pcb_pkg::*;
#(
   parameter int              ID_W     = 2,
   parameter logic [ID_W-1:0] TOK_CODE = 2'b01,
   parameter logic [ID_W-1:0] DAT_CODE = 2'b11,
   parameter logic [ID_W-1:0] HS_CODE  = 2'b10
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [ID_W-1:0] hold,
   input  logic            cap_done,
   output cls_vec_t        hit,
   output cls_vec_t        pulse,
   output logic            bank_sel,
   output logic            restart
);
   localparam logic [ID_W-1:0] CODE [NCLS] = '{TOK_CODE, DAT_CODE, HS_CODE};
   localparam logic            BANK [NCLS] = '{BANK_TOKEN, BANK_DATA, BANK_DATA};

   if (TOK_CODE == DAT_CODE || TOK_CODE == HS_CODE || DAT_CODE == HS_CODE) begin : g_bad_codes
      $error("pcb_classify: class codes must be distinct");
   end

   for (genvar gi = 0; gi < NCLS; gi++) begin : g_match
      assign hit[gi] = cap_done && (hold == CODE[gi]);
   end

   logic bank_n;
   always_comb begin
      bank_n = bank_sel;
      for (int i = 0; i < NCLS; i++) begin
         if (hit[i]) bank_n = BANK[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pulse    <= '0;
         bank_sel <= BANK_TOKEN;
         restart  <= 1'b0;
      end else begin
         pulse    <= hit;
         bank_sel <= bank_n;
         restart  <= |hit;
      end
   end

   // R6
   no_hit_bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (hit == '0) |=> $stable(bank_sel));
endmodule

// File: rtl/pcb_status.sv
module pcb_status #(
   parameter int N        = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] stat
);
   if (N < 1) begin : g_bad_n
      $error("pcb_status: N must be positive");
   end

   for (genvar gi = 0; gi < N; gi++) begin : g_bit
      logic nxt;
      if (SET_WINS) begin : g_set_first
         assign nxt = set[gi] | (stat[gi] & ~clr);
      end else begin : g_clr_first
         assign nxt = (set[gi] | stat[gi]) & ~clr;
      end

      always_ff @(posedge clk) begin
         if (rst) stat[gi] <= 1'b0;
         else     stat[gi] <= nxt;
      end

      if (SET_WINS) begin : g_chk
         // R9
         set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
            set[gi] |=> stat[gi]);
      end
   end

   // R9
   hold_without_event_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr && set == '0) |=> $stable(stat));
endmodule

// File: rtl/pkt_class_buf.sv
module pkt_class_buf
   import pcb_pkg::*;
#(
   parameter int                 ID_BITS  = 2,
   parameter logic [ID_BITS-1:0] TOK_CODE = 2'b01,
   parameter logic [ID_BITS-1:0] DAT_CODE = 2'b11,
   parameter logic [ID_BITS-1:0] HS_CODE  = 2'b10,
   parameter bit                 SET_WINS = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       rx_bit,
   input  logic       bit_valid,
   input  logic       pkt_start,
   input  logic       stat_clr,
   output logic [2:0] rx_stat,
   output logic       bank_sel,
   output logic       tok_det,
   output logic       dat_det,
   output logic       hs_det,
   output logic       ptr_restart
);
   logic [ID_BITS-1:0] hold;
   logic               cap_done;
   cls_vec_t           hit;
   cls_vec_t           pulse;

   pcb_capture #(.ID_W(ID_BITS)) u_cap (
      .clk(clk), .rst(rst), .rx_bit(rx_bit), .bit_valid(bit_valid),
      .pkt_start(pkt_start), .hold(hold), .cap_done(cap_done)
   );

   pcb_classify #(
      .ID_W(ID_BITS), .TOK_CODE(TOK_CODE), .DAT_CODE(DAT_CODE), .HS_CODE(HS_CODE)
   ) u_cls (
      .clk(clk), .rst(rst), .hold(hold), .cap_done(cap_done), .hit(hit),
      .pulse(pulse), .bank_sel(bank_sel), .restart(ptr_restart)
   );

   pcb_status #(.N(NCLS), .SET_WINS(SET_WINS)) u_stat (
      .clk(clk), .rst(rst), .set(hit), .clr(stat_clr), .stat(rx_stat)
   );

   assign tok_det = pulse[CLS_TOK];
   assign dat_det = pulse[CLS_DAT];
   assign hs_det  = pulse[CLS_HS];

   // R8
   restart_one_class_chk: assert property (@(posedge clk) disable iff (rst)
      ptr_restart |-> $onehot({hs_det, dat_det, tok_det}));

   // R3
   token_bank_chk: assert property (@(posedge clk) disable iff (rst)
      tok_det |-> (bank_sel == BANK_TOKEN));

   // R5
   hs_bank_chk: assert property (@(posedge clk) disable iff (rst)
      hs_det |-> (bank_sel == BANK_DATA));

   // R7
   pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      (tok_det || dat_det || hs_det) |-> !$past(tok_det || dat_det || hs_det) || $past(cap_done));
endmodule

// File: tb/pkt_class_buf_test.sv
module pkt_class_buf_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rx_bit = 1'b0, bit_valid = 1'b0, pkt_start = 1'b0, stat_clr = 1'b0;
   logic [2:0] rx_stat;
   logic bank_sel, tok_det, dat_det, hs_det, ptr_restart;

   pkt_class_buf uut (
      .clk(clk), .rst(rst), .rx_bit(rx_bit), .bit_valid(bit_valid),
      .pkt_start(pkt_start), .stat_clr(stat_clr), .rx_stat(rx_stat),
      .bank_sel(bank_sel), .tok_det(tok_det), .dat_det(dat_det),
      .hs_det(hs_det), .ptr_restart(ptr_restart)
   );

   always #5 clk = ~clk;

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    started = 1'b0;

   // behavioural reference model
   int         ph = 0;
   bit         m0 = 0, m1 = 0, pend = 0;
   logic [2:0] e_stat = 0, e_pulse = 0, s = 0;
   logic       e_bank = 0, e_rst = 0;

   always @(posedge clk) begin
      started <= 1'b1;
      if (rst) begin
         ph = 0; m0 = 0; m1 = 0; pend = 0;
         e_stat = 0; e_pulse = 0; e_bank = 0; e_rst = 0;
      end else begin
         s = 3'b000;
         if (pend) begin
            case ({m1, m0})
               2'b01:   s = 3'b001;
               2'b11:   s = 3'b010;
               2'b10:   s = 3'b100;
               default: s = 3'b000;
            endcase
         end
         pend    = 0;
         e_stat  = (stat_clr ? 3'b000 : e_stat) | s;
         e_pulse = s;
         e_rst   = (s != 0);
         if (s[0]) e_bank = 1'b0;
         else if (s != 0) e_bank = 1'b1;
         if (pkt_start) begin
            ph = 1;
            if (bit_valid) begin m0 = rx_bit; ph = 2; end
         end else if (bit_valid && ph == 1) begin
            m0 = rx_bit; ph = 2;
         end else if (bit_valid && ph == 2) begin
            m1 = rx_bit; pend = 1; ph = 0;
         end
      end
   end

   task automatic cmp(string what, logic [2:0] act, logic [2:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         cmp("rx_stat", rx_stat, e_stat);
         cmp("pulses {hs,dat,tok}", {hs_det, dat_det, tok_det}, e_pulse);
         cmp("bank_sel", {2'b00, bank_sel}, {2'b00, e_bank});
         cmp("ptr_restart", {2'b00, ptr_restart}, {2'b00, e_rst});
      end
   end

   task automatic drive(bit ps, bit bv, bit b, bit clr);
      pkt_start = ps; bit_valid = bv; rx_bit = b; stat_clr = clr;
      @(negedge clk);
   endtask

   task automatic send(bit b0, bit b1, bit clr_at_cls);
      drive(1, 1, b0, 0);
      drive(0, 1, b1, 0);
      drive(0, 0, 0, clr_at_cls);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
   endtask

   initial begin
      #1ms;
      n_bad++;
      $display("FAIL watchdog R7: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      cur_req = "R1";
      @(negedge clk); @(negedge clk); @(negedge clk);
      rst = 1'b0;
      idle(2);
      cur_req = "R3";  send(1, 0, 0); idle(3);
      cur_req = "R4";  send(1, 1, 0); idle(3);
      cur_req = "R5";  send(0, 1, 0); idle(3);
      cur_req = "R6";  send(0, 0, 0); idle(3);
      cur_req = "R9";  drive(0, 0, 0, 1); idle(2);
      send(1, 0, 1); idle(2);
      send(0, 1, 0); drive(0, 0, 0, 1); idle(2);
      cur_req = "R2";
      drive(0, 1, 1, 0); drive(0, 1, 1, 0);
      drive(1, 0, 0, 0); drive(0, 0, 1, 0); drive(0, 1, 0, 0);
      drive(0, 0, 0, 0); drive(0, 1, 1, 0); idle(3);
      cur_req = "R10";
      send(1, 1, 0); drive(0, 1, 0, 0); drive(0, 1, 1, 0); drive(0, 1, 0, 0); idle(2);
      drive(1, 1, 1, 0); drive(1, 1, 0, 0); drive(0, 1, 1, 0); idle(3);
      cur_req = "R7 R8";
      drive(1, 1, 1, 0); drive(0, 1, 0, 0);
      drive(1, 1, 1, 0); drive(0, 1, 1, 0);
      drive(1, 1, 0, 0); drive(0, 1, 1, 0); idle(3);
      cur_req = "R2 R10 R9";
      for (int i = 0; i < 3000; i++) begin
         drive(($urandom % 6) == 0, ($urandom % 3) != 0, $urandom % 2, ($urandom % 17) == 0);
      end
      cur_req = "R1";
      send(1, 1, 0);
      rst = 1'b1; idle(3); rst = 1'b0;
      idle(2);
      cur_req = "R3";  send(1, 0, 0); idle(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule